// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Condition Flags

This unit performs one shift or rotate per clock on the low byte, word or long of a 32-bit operand. It covers eight operations: arithmetic left and right shifts, logical left and right shifts, plain rotates in both directions, and rotates in both directions through the extend flag. The shift count comes either from a 3-bit immediate field or from a 6-bit register count. Bits of the operand above the selected size pass through unchanged.

Alongside the result, the unit produces the five condition flags X, N, Z, V and C, and a write enable for each flag. Each family has its own rule for X, C and V, including a separate rule for a count of zero. The computation is combinational. The result, flags and enables are registered once, so everything for an operation appears on the outputs one clock after the inputs are presented. A surrounding datapath supplies the operands and writes back the result and the enabled flags.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst_n` is low, and after a reset clock, `result_o`, `flags_o` and `flags_we_o` are all zero. Otherwise every output reflects the inputs presented one clock earlier.
- R2: When `cnt_reg_sel_i` is 0, the count is `imm_cnt_i`, with the value 0 meaning 8. When it is 1, the count is `reg_cnt_i`, which runs from 0 to 63 and may exceed the operand width.
- R3: `size_i` encodes the operand width: 0 is byte (8 bits), 1 is word (16 bits), and 2 or 3 is long (32 bits). Result bits above the width equal the operand. N (`flags_o[3]`) is the top bit of the sized result. Z (`flags_o[2]`) is 1 exactly when the sized result is zero.
- R4: For the left shifts (`op_i` 0 arithmetic, 2 logical), zeros fill from the right, and a count at or above the width gives zero. C (`flags_o[0]`) and X (`flags_o[4]`) take the last bit shifted out, which is 0 when the count exceeds the width.
- R5: The logical right shift (`op_i` 3) fills with zeros. The arithmetic right shift (`op_i` 1) fills with the sign bit, so a count at or above the width gives all sign bits. C and X take the last bit shifted out.
- R6: V (`flags_o[1]`) is 1 only for an arithmetic left shift in which the top bit takes more than one value over the course of the shift. V is 0 for every other operation.
- R7: The plain rotates (`op_i` 4 left, 5 right) wrap by the count modulo the width. C takes the last bit rotated out. X is not written.
- R8: The rotates through extend (`op_i` 6 left, 7 right) rotate a ring of width+1 bits made of the sized operand and the incoming `x_i`. The rotation is by the count modulo width+1. Both X and C take the ring bit that ends up in the X position.
- R9: With a count of zero the result equals the operand, and X is not written. C is cleared for the shifts and plain rotates, and C equals `x_i` for the rotates through extend.
- R10: The enables for N, Z, V and C (`flags_we_o[3:0]`) are always 1. The X enable (`flags_we_o[4]`) is 1 exactly for a shift or a rotate through extend with a nonzero count. When X is not written, `flags_o[4]` equals `x_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_i | input | 32 | Operand |
| size_i | input | 2 | Operand size code |
| op_i | input | 3 | Operation code |
| cnt_reg_sel_i | input | 1 | 1 selects the register count, 0 selects the immediate count |
| imm_cnt_i | input | 3 | Immediate count field (0 means 8) |
| reg_cnt_i | input | 6 | Register count, 0 to 63 |
| x_i | input | 1 | Incoming extend flag |
| result_o | output | 32 | Result, with only the sized low part modified |
| flags_o | output | 5 | Flags {X,N,Z,V,C} |
| flags_we_o | output | 5 | Per-flag write enables, same bit order |

## Verification
The result, the five flags and the five enables all leave through one register stage, so each is due exactly one clock after the inputs that produce it. The bench applies each vector on a falling edge and samples one time step after the following rising edge. At that point every output belongs to that vector alone. The assertions also pair each output with the inputs captured one edge earlier, and they skip the first edge after reset.

// File: rtl/shr_pkg.sv
// Shared definitions for the shift/rotate unit: operation and size codes
// and a helper that rotates a ring of variable width.
// Assumes ring widths up to 33 bits held in a 64-bit container.
package shr_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;
    localparam int IMM_W  = 3;
    localparam int FLAG_W = 5;
    localparam int X_BIT  = 4;
    localparam int N_BIT  = 3;
    localparam int Z_BIT  = 2;
    localparam int V_BIT  = 1;
    localparam int C_BIT  = 0;

    typedef enum logic [2:0] {
        OP_ASL = 3'd0, OP_ASR = 3'd1, OP_LSL = 3'd2, OP_LSR = 3'd3,
        OP_ROL = 3'd4, OP_ROR = 3'd5, OP_RXL = 3'd6, OP_RXR = 3'd7
    } shr_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_LONG2 = 2'd3
    } shr_size_e;

    // Rotate the low n bits of v left by r (0 <= r <= n); upper bits cleared.
    function automatic logic [63:0] rotl(input logic [63:0] v,
                                         input logic [CNT_W-1:0] n,
                                         input logic [CNT_W-1:0] r);
        logic [63:0] nmask;
        nmask = (64'h1 << n) - 64'h1;
        return ((v << r) | (v >> (n - r))) & nmask;
    endfunction
endpackage

// File: rtl/shr_count.sv
// Count selection: picks the immediate or the register count.
// Assumes an immediate field of 0 stands for the maximum immediate count.
module shr_count
    import shr_pkg::*;
(
    input  logic             use_reg,
    input  logic [IMM_W-1:0] imm_cnt,
    input  logic [CNT_W-1:0] reg_cnt,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] IMM_MAX = CNT_W'(1 << IMM_W);

    // Decode the effective count.
    always_comb begin
        if (use_reg)
            cnt = reg_cnt;
        else if (imm_cnt == '0)
            cnt = IMM_MAX;
        else
            cnt = CNT_W'(imm_cnt);
    end
endmodule

// File: rtl/shr_datapath.sv
// Combinational shift/rotate core. Works on an operand already masked to
// the active width w (8, 16 or 32); returns the sized result, the last bit
// out, the overflow and the new extend value.
module shr_datapath
    import shr_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [CNT_W-1:0]  w,
    input  logic [CNT_W-1:0]  k,
    input  shr_op_e           op,
    input  logic              x_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              v_out,
    output logic              x_new
);
    logic [63:0]        ext, mask64, sh, rr, ring, se;
    logic [DATA_W-1:0]  mask, tm;
    logic signed [64:0] sgn_t;
    logic [CNT_W-1:0]   r_plain, r_ext, n_ext;
    logic               sgn, kz;

    // Shared operand forms and rotate amounts.
    always_comb begin
        ext     = {32'b0, a};
        mask64  = (64'h1 << w) - 64'h1;
        mask    = mask64[DATA_W-1:0];
        sgn     = a[w - 6'd1];
        se      = {{32{sgn}}, a | (sgn ? ~mask : '0)};
        kz      = (k == '0);
        r_plain = k & (w - 6'd1);
        n_ext   = w + 6'd1;
        ring    = ext | ({63'b0, x_in} << w);
        case (w)
            6'd8:    r_ext = k % 6'd9;
            6'd16:   r_ext = k % 6'd17;
            default: r_ext = k % 6'd33;
        endcase
    end

    // Per-operation result, last-bit-out and overflow.
    always_comb begin
        sh    = '0;
        rr    = '0;
        sgn_t = '0;
        tm    = '0;
        res   = '0;
        c_out = 1'b0;
        v_out = 1'b0;
        x_new = x_in;
        case (op)
            OP_ASL, OP_LSL: begin
                sh    = ext << k;
                res   = sh[DATA_W-1:0] & mask;
                c_out = !kz && sh[w];
                if (op == OP_ASL && !kz) begin
                    if (k >= w) begin
                        v_out = (a != '0);
                    end else begin
                        tm    = mask & ~(mask >> (k + 6'd1));
                        v_out = ((a & tm) != '0) && ((a & tm) != tm);
                    end
                end
                x_new = c_out;
            end
            OP_LSR: begin
                sh    = {31'b0, a, 1'b0} >> k;
                res   = a >> k;
                c_out = !kz && sh[0];
                x_new = c_out;
            end
            OP_ASR: begin
                sgn_t = $signed({se, 1'b0}) >>> k;
                res   = sgn_t[DATA_W:1] & mask;
                c_out = !kz && sgn_t[0];
                x_new = c_out;
            end
            OP_ROL, OP_ROR: begin
                rr    = (op == OP_ROL) ? rotl(ext, w, r_plain)
                                       : rotl(ext, w, w - r_plain);
                res   = rr[DATA_W-1:0];
                c_out = !kz && ((op == OP_ROL) ? rr[0] : rr[w - 6'd1]);
            end
            default: begin
                rr    = (op == OP_RXL) ? rotl(ring, n_ext, r_ext)
                                       : rotl(ring, n_ext, n_ext - r_ext);
                res   = rr[DATA_W-1:0] & mask;
                x_new = rr[w];
                c_out = x_new;
            end
        endcase
    end
endmodule

// File: rtl/shr_flags.sv
// Flag and write-enable generation from the sized result and core outputs.
// Assumes res carries zeros above the active width w.
module shr_flags
    import shr_pkg::*;
(
    input  logic [DATA_W-1:0] res,
    input  logic [CNT_W-1:0]  w,
    input  logic [CNT_W-1:0]  k,
    input  shr_op_e           op,
    input  logic              x_in,
    input  logic              c_in,
    input  logic              v_in,
    input  logic              x_new,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] flags_we
);
    logic x_wr;

    // Assemble {X,N,Z,V,C} and their enables.
    always_comb begin
        x_wr            = (k != '0) && (op != OP_ROL) && (op != OP_ROR);
        flags           = '0;
        flags[X_BIT]    = x_wr ? x_new : x_in;
        flags[N_BIT]    = res[w - 6'd1];
        flags[Z_BIT]    = (res == '0);
        flags[V_BIT]    = v_in;
        flags[C_BIT]    = c_in;
        flags_we        = '1;
        flags_we[X_BIT] = x_wr;
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// Top level: sized shift/rotate with flags, one register stage on the
// outputs. Reset is synchronous and active low.
module shift_rotate_unit
    import shr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       opnd_i,
    input  logic [1:0]        size_i,
    input  logic [2:0]        op_i,
    input  logic              cnt_reg_sel_i,
    input  logic [2:0]        imm_cnt_i,
    input  logic [5:0]        reg_cnt_i,
    input  logic              x_i,
    output logic [31:0]       result_o,
    output logic [4:0]        flags_o,
    output logic [4:0]        flags_we_o
);
    logic [CNT_W-1:0]  w, k;
    logic [DATA_W-1:0] mask, a_m, res_s;
    logic [FLAG_W-1:0] flags_d, we_d;
    logic              c_d, v_d, x_d;
    shr_op_e           op;

    // Width decode and operand masking.
    always_comb begin
        op = shr_op_e'(op_i);
        case (shr_size_e'(size_i))
            SZ_BYTE: w = 6'd8;
            SZ_WORD: w = 6'd16;
            default: w = 6'd32;
        endcase
        mask = (w == 6'd32) ? '1 : ((32'h1 << w) - 32'h1);
        a_m  = opnd_i & mask;
    end

    shr_count u_count (
        .use_reg (cnt_reg_sel_i),
        .imm_cnt (imm_cnt_i),
        .reg_cnt (reg_cnt_i),
        .cnt     (k)
    );

    shr_datapath u_dp (
        .a     (a_m),
        .w     (w),
        .k     (k),
        .op    (op),
        .x_in  (x_i),
        .res   (res_s),
        .c_out (c_d),
        .v_out (v_d),
        .x_new (x_d)
    );

    shr_flags u_flags (
        .res      (res_s),
        .w        (w),
        .k        (k),
        .op       (op),
        .x_in     (x_i),
        .c_in     (c_d),
        .v_in     (v_d),
        .x_new    (x_d),
        .flags    (flags_d),
        .flags_we (we_d)
    );

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o   <= '0;
            flags_o    <= '0;
            flags_we_o <= '0;
        end else begin
            result_o   <= (opnd_i & ~mask) | res_s;
            flags_o    <= flags_d;
            flags_we_o <= we_d;
        end
    end
endmodule

// File: rtl/shr_checker.sv
// Property checker for shift_rotate_unit, attached with bind below.
// Relates registered outputs to the inputs captured one edge earlier.
module shr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] opnd_i,
    input logic [1:0]  size_i,
    input logic [2:0]  op_i,
    input logic        x_i,
    input logic [31:0] result_o,
    input logic [4:0]  flags_o,
    input logic [4:0]  flags_we_o
);
    AST_ROTATE_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == 3'd4 || $past(op_i) == 3'd5))
        |-> (!flags_we_o[4] && flags_o[4] == $past(x_i)));            // R7
    AST_V_ONLY_ASL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) != 3'd0) |-> !flags_o[1]);        // R6
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(size_i) == 2'd0)
        |-> result_o[31:8] == $past(opnd_i[31:8]));                    // R3
    AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags_o[3] && flags_o[2]));                                  // R3
    AST_CORE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> flags_we_o[3:0] == 4'hF);                     // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !$past(rst_n) |-> (result_o == '0 && flags_we_o == '0));       // R1
endmodule

bind shift_rotate_unit shr_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .opnd_i     (opnd_i),
    .size_i     (size_i),
    .op_i       (op_i),
    .x_i        (x_i),
    .result_o   (result_o),
    .flags_o    (flags_o),
    .flags_we_o (flags_we_o)
);

// File: tb/shift_rotate_unit_tb_top.sv
`timescale 1ns/1ps
module shift_rotate_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_i = '0;
    logic [1:0]  size_i = '0;
    logic [2:0]  op_i = '0;
    logic        cnt_reg_sel_i = 1'b0;
    logic [2:0]  imm_cnt_i = '0;
    logic [5:0]  reg_cnt_i = '0;
    logic        x_i = 1'b0;
    logic [31:0] result_o;
    logic [4:0]  flags_o, flags_we_o;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shift_rotate_unit dut_i (
        .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .size_i(size_i),
        .op_i(op_i), .cnt_reg_sel_i(cnt_reg_sel_i), .imm_cnt_i(imm_cnt_i),
        .reg_cnt_i(reg_cnt_i), .x_i(x_i), .result_o(result_o),
        .flags_o(flags_o), .flags_we_o(flags_we_o)
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Step-by-step reference: applies k single-bit moves.
    task automatic model(input int op, input int sz, input logic [31:0] a0,
                         input int k, input logic xin,
                         output logic [31:0] r, output logic [4:0] f,
                         output logic [4:0] we);
        int w;
        logic [31:0] m, a;
        logic c, x, v, msb0;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        a = a0 & m; x = xin; c = 1'b0; v = 1'b0; msb0 = a[w-1];
        for (int i = 0; i < k; i++) begin
            case (op)
                0, 2: begin c = a[w-1]; a = (a << 1) & m;
                            if (op == 0 && a[w-1] != msb0) v = 1'b1; end
                1: begin c = a[0]; a = (a >> 1) | (32'(a[w-1]) << (w-1)); end
                3: begin c = a[0]; a = a >> 1; end
                4: begin c = a[w-1]; a = ((a << 1) | 32'(c)) & m; end
                5: begin c = a[0]; a = (a >> 1) | (32'(c) << (w-1)); end
                6: begin c = a[w-1]; a = ((a << 1) | 32'(x)) & m; x = c; end
                default: begin c = a[0]; a = (a >> 1) | (32'(x) << (w-1)); x = c; end
            endcase
        end
        if (k == 0) c = (op >= 6) ? xin : 1'b0;
        we = 5'b01111;
        if (k != 0 && op != 4 && op != 5) begin
            we[4] = 1'b1;
            x = c;
        end else begin
            x = xin;
        end
        r = (a0 & ~m) | a;
        f = {x, a[w-1], (a == 0), v, c};
    endtask

    task automatic apply(input int op, input int sz, input logic [31:0] a,
                         input bit sel, input int cnt, input logic xin);
        @(negedge clk);
        op_i = 3'(op); size_i = 2'(sz); opnd_i = a; x_i = xin;
        cnt_reg_sel_i = sel;
        imm_cnt_i = 3'(cnt); reg_cnt_i = 6'(cnt);
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] pats [6];
        logic [31:0] er;
        logic [4:0] ef, ew;
        string rq;
        pats[0] = 32'h1234_56E9; pats[1] = 32'h0000_0000;
        pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h8000_8080;
        pats[4] = 32'h4000_406B; pats[5] = 32'h7FFF_FF01;
        opnd_i = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk); #1;
        check("R1 reset result", result_o, 32'h0);
        check("R1 reset flags", {27'b0, flags_o}, 32'h0);
        check("R1 reset enables", {27'b0, flags_we_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // Known cases: ASL 0x6B by 1 byte; ASR 0xE9 by 3 byte.
        apply(0, 0, 32'h0000_006B, 1'b0, 1, 1'b1);
        check("R4 asl byte result", result_o, 32'h0000_00D6);
        check("R6 asl byte flags XNZVC", {27'b0, flags_o}, 32'h0000_000A);
        apply(1, 0, 32'h0000_00E9, 1'b0, 3, 1'b0);
        check("R5 asr byte result", result_o, 32'h0000_00FD);
        apply(3, 1, 32'h0000_8001, 1'b0, 0, 1'b0);
        check("R2 imm 0 means 8", result_o, 32'h0000_0080);

        for (int op = 0; op < 8; op++) begin
            rq = (op < 1 || op == 2) ? "R4" : (op < 4) ? "R5" :
                 (op < 6) ? "R7" : "R8";
            for (int sz = 0; sz < 3; sz++)
                for (int p = 0; p < 6; p++)
                    for (int c = 0; c < 72; c++) begin
                        bit sel;
                        int k, cf;
                        logic xin;
                        sel = (c >= 8);
                        cf  = sel ? c - 8 : c;
                        k   = sel ? cf : ((cf == 0) ? 8 : cf);
                        xin = logic'((p + c) % 2);
                        apply(op, sz, pats[p], sel, cf, xin);
                        model(op, sz, pats[p], k, xin, er, ef, ew);
                        check(sel ? rq : {rq, " R2"}, result_o, er);
                        check("R3 N Z", {30'b0, flags_o[3:2]}, {30'b0, ef[3:2]});
                        check("R6 V", {31'b0, flags_o[1]}, {31'b0, ef[1]});
                        check(k == 0 ? "R9 C X" : "R4 R5 R7 R8 C X",
                              {30'b0, flags_o[4], flags_o[0]},
                              {30'b0, ef[4], ef[0]});
                        check("R10 enables", {27'b0, flags_we_o}, {27'b0, ew});
                    end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule